// File: doc/BRIEF.md
# Serial Two-Channel Step Attenuator Control

This block receives control words for two 5-bit step attenuators over a three-wire serial link. The link has data, a serial clock and an active-low select. All three serial pins are resynchronised into the system clock, and their edges are detected there. Every rising edge of the serial clock shifts one data bit into a ten-bit register, whatever the level of the select. A rising edge on the select copies the ten bits that arrived most recently into two held 5-bit codes. It also raises a one-cycle update strobe.

The held codes are active-low. Each zero bit adds its binary weight in dB: 16, 8, 4, 2 and 1 from the field's top bit down. Each code is also decoded into an attenuation figure. That figure saturates at the usable limit of 28 dB, while the raw code is still reported. A separate active-low loopback enable pin is synchronised and brought out as an active-high flag. The serial clock must be sampled at least four times per period by the system clock.

Top module: `atten_serial_ctl`

## Requirements
- R1: Bits are shifted most significant first. After ten serial clocks, the first bit received lands in bit 9 of the word and the last in bit 0.
- R2: A serial clock rising edge shifts a bit whether the select is high or low. Bits clocked while the select is high are latched by a later select rise that has no serial clocks of its own.
- R3: The held codes, the dB outputs and the strobe change only on a detected select rising edge. Serial clocks alone leave every output unchanged.
- R4: Channel A takes word bits 9..5 and appears on `att_code_o[9:5]`. Channel B takes bits 4..0 and appears on `att_code_o[4:0]`. The dB outputs use the same split.
- R5: The dB value of a field is 31 minus the code: 11111 gives 0 dB, 11110 gives 1 dB, and 01111 gives 16 dB.
- R6: Codes 00000, 00001 and 00010 report 28 dB rather than 31, 30 and 29 dB. The raw code output still shows the code that was written.
- R7: `lpbk_on_o` is the inverse of `lpbk_en_n_i` after the synchroniser, so a 0 on the pin gives 1 on the output.
- R8: During and after reset, both codes are 00000, both dB outputs are 28, the strobe is 0, the loopback flag is 0 and the shift register is cleared.
- R9: When more than ten serial clocks arrive before a select rise, only the last ten bits are latched.
- R10: `update_o` is high for exactly one system cycle each time the held codes are reloaded. It is high in the same cycle that the new codes first appear.
- R11: A serial clock rise and a select rise that are detected in the same system cycle latch a word that includes the bit shifted by that clock.

Latency: an output changes three system clock edges after the pin transition that causes it. Two of those edges are in the synchroniser and one is in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_csn_i | input | 1 | Active-low serial select, asynchronous |
| lpbk_en_n_i | input | 1 | Active-low loopback enable |
| att_code_o | output | 10 | Held raw codes: A in [9:5], B in [4:0] |
| att_db_o | output | 10 | Clamped attenuation in dB: A in [9:5], B in [4:0] |
| lpbk_on_o | output | 1 | Loopback path enabled |
| update_o | output | 1 | One-cycle strobe when the codes reload |

## Verification
The shift and the latch can fall in the same system cycle. This happens when the final serial clock rise and the select rise reach the pins together. The bench provokes it by raising both pins at the same instant. It then expects a latched word that already contains that last bit (R11). A design that latches the pre-shift register instead loses that bit and shows a word shifted by one position. The scoreboard catches that mismatch.

// File: rtl/atten_ctl_pkg.sv
package atten_ctl_pkg;
  localparam int FIELD_W  = 5;
  localparam int NUM_ATT  = 2;
  localparam int WORD_W   = FIELD_W * NUM_ATT;
  localparam int MAX_DB   = 28;
  localparam int SYNC_LEN = 2;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [WORD_W-1:0]  word_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_o,
  output logic [W-1:0] word_next_o
);
  logic [W-1:0] word_q;

  // new bits enter at the bottom, so the first bit sent ends up on top
  assign word_next_o = shift_en ? {word_q[W-2:0], bit_in} : word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_next_o;
  end

  assign word_o = word_q;

  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word_q[0] == $past(bit_in)) && (word_q[W-1:1] == $past(word_q[W-2:0])));
endmodule

// File: rtl/code_to_db.sv
module code_to_db #(
  parameter int FW  = 5,
  parameter int LIM = 28
) (
  input  logic [FW-1:0] code_i,
  output logic [FW-1:0] db_o
);
  localparam logic [FW-1:0] FULL  = {FW{1'b1}};
  localparam logic [FW-1:0] LIMIT = FW'(LIM);

  logic [FW-1:0] raw_db;

  // active-low weights: every cleared bit adds its binary weight
  assign raw_db = FULL - code_i;
  assign db_o   = (raw_db > LIMIT) ? LIMIT : raw_db;
endmodule

// File: rtl/atten_serial_ctl.sv
module atten_serial_ctl
  import atten_ctl_pkg::*;
#(
  parameter int FW  = FIELD_W,
  parameter int NA  = NUM_ATT,
  parameter int LIM = MAX_DB,
  parameter int SYN = SYNC_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_csn_i,
  input  logic             lpbk_en_n_i,
  output logic [FW*NA-1:0] att_code_o,
  output logic [FW*NA-1:0] att_db_o,
  output logic             lpbk_on_o,
  output logic             update_o
);
  localparam int WW   = FW * NA;
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b1100; // lpbk_n, csn idle high

  logic [NPIN-1:0] pin_raw, pin_s;
  assign pin_raw = {lpbk_en_n_i, ser_csn_i, ser_dat_i, ser_clk_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    pin_sync #(.STAGES(SYN), .RST_VAL(PIN_RST[p])) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_raw[p]),
      .q_o (pin_s[p])
    );
  end

  logic sclk_s, dat_s, csn_s, lpn_s;
  assign {lpn_s, csn_s, dat_s, sclk_s} = pin_s;

  logic sclk_d, csn_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  logic sclk_rise, cs_rise;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = csn_s & ~csn_d;

  logic [WW-1:0] sh_word, sh_next;
  bit_shifter #(.W(WW)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .shift_en    (sclk_rise),
    .bit_in      (dat_s),
    .word_o      (sh_word),
    .word_next_o (sh_next)
  );

  // decode the word as it will stand after this cycle's shift
  logic [WW-1:0] db_next;
  for (genvar a = 0; a < NA; a++) begin : g_dec
    code_to_db #(.FW(FW), .LIM(LIM)) u_dec (
      .code_i (sh_next[a*FW +: FW]),
      .db_o   (db_next[a*FW +: FW])
    );
  end

  localparam logic [FW-1:0] LIMV = FW'(LIM);

  logic [WW-1:0] code_q, db_q;
  logic          upd_q, lpbk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      db_q   <= {NA{LIMV}};
      upd_q  <= 1'b0;
      lpbk_q <= 1'b0;
    end else begin
      upd_q  <= cs_rise;
      lpbk_q <= ~lpn_s;
      if (cs_rise) begin
        code_q <= sh_next;
        db_q   <= db_next;
      end
    end
  end

  assign att_code_o = code_q;
  assign att_db_o   = db_q;
  assign update_o   = upd_q;
  assign lpbk_on_o  = lpbk_q;

  // R3
  codes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (att_code_o != $past(att_code_o)) |-> update_o);

  // R10
  update_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);

  for (genvar a = 0; a < NA; a++) begin : g_chk
    // R6
    db_limit_chk: assert property (@(posedge clk) disable iff (rst)
      att_db_o[a*FW +: FW] <= LIMV);
  end

  // R8
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (att_code_o == '0) && !update_o && !lpbk_on_o);
endmodule

// File: tb/atten_serial_ctl_tb.sv
module atten_serial_ctl_tb;
  localparam int PERIOD = 10;
  localparam int HALF_BIT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1, lpbk_n = 1'b1;
  logic [9:0] code_o, db_o;
  logic lpbk_on, upd;

  int checks = 0, errors = 0;
  logic [19:0] exp_q [$];

  always #(PERIOD/2) clk = ~clk;

  atten_serial_ctl u_dut (
    .clk         (clk),
    .rst         (rst),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .ser_csn_i   (ser_csn),
    .lpbk_en_n_i (lpbk_n),
    .att_code_o  (code_o),
    .att_db_o    (db_o),
    .lpbk_on_o   (lpbk_on),
    .update_o    (upd)
  );

  function automatic logic [4:0] db_of(input logic [4:0] c);
    int v;
    v = 31 - int'(c);
    if (v > 28) v = 28;
    return 5'(v);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    wait_cyc(HALF_BIT);
    ser_clk = 1'b1;
    wait_cyc(HALF_BIT);
    ser_clk = 1'b0;
  endtask

  task automatic push_exp(input logic [9:0] w);
    exp_q.push_back({w, db_of(w[9:5]), db_of(w[4:0])});
  endtask

  // frame of n bits, word value in the low n bits of w, MSB first
  task automatic send_bits(input logic [15:0] w, input int n, input bit with_cs);
    if (with_cs) ser_csn = 1'b0;
    for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
    wait_cyc(HALF_BIT);
    if (with_cs) begin
      push_exp(w[9:0]);
      ser_csn = 1'b1;
      wait_cyc(8);
    end
  endtask

  // last serial clock rise and select rise at the same instant
  task automatic send_coincident(input logic [9:0] w);
    ser_csn = 1'b0;
    for (int i = 9; i >= 1; i--) ser_bit(w[i]);
    ser_dat = w[0];
    wait_cyc(HALF_BIT);
    push_exp(w);
    ser_clk = 1'b1;
    ser_csn = 1'b1;
    wait_cyc(HALF_BIT);
    ser_clk = 1'b0;
    wait_cyc(8);
  endtask

  // monitor: every strobe pops one expected item (R3, R4, R5, R6, R10)
  always @(negedge clk) begin
    if (!rst && upd) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected update actual=%h expected=none", code_o);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        check("R4 code", {22'd0, code_o}, {22'd0, e[19:10]});
        check("R5 R6 db", {22'd0, db_o}, {22'd0, e[9:0]});
      end
    end
  end

  // R10: the strobe lasts a single cycle
  logic upd_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && upd && upd_prev) begin
      checks++;
      errors++;
      $display("FAIL R10 strobe longer than one cycle actual=1 expected=0");
    end
    upd_prev <= upd;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    // R8 reset state
    check("R8 code", {22'd0, code_o}, 32'd0);
    check("R8 db", {22'd0, db_o}, {22'd0, 5'd28, 5'd28});
    check("R8 upd", {31'd0, upd}, 32'd0);
    check("R8 lpbk", {31'd0, lpbk_on}, 32'd0);
    rst = 1'b0;
    wait_cyc(5);

    // R1 R4 R5: A=11110 (1 dB), B=01111 (16 dB)
    send_bits(16'b11110_01111, 10, 1'b1);
    // R5: minimum attenuation both
    send_bits(16'b11111_11111, 10, 1'b1);
    // R6: clamp codes 00000 / 00010, raw code kept
    send_bits(16'b00000_00010, 10, 1'b1);
    send_bits(16'b00001_00011, 10, 1'b1);
    check("R6 raw", {22'd0, code_o}, {22'd0, 10'b00001_00011});

    // R3 R2: shift while select high, outputs unchanged
    send_bits(16'b10101_01010, 10, 1'b0);
    wait_cyc(6);
    check("R3 hold", {22'd0, code_o}, {22'd0, 10'b00001_00011});
    // R2: bare select pulse latches the previously shifted bits
    ser_csn = 1'b0;
    wait_cyc(6);
    push_exp(10'b10101_01010);
    ser_csn = 1'b1;
    wait_cyc(8);
    check("R2 latched", {22'd0, code_o}, {22'd0, 10'b10101_01010});

    // R9: 13 bits, only the last ten kept
    ser_csn = 1'b0;
    for (int i = 12; i >= 0; i--) ser_bit(i >= 10 ? 1'b0 : ((10'b11001_00111 >> i) & 1));
    wait_cyc(HALF_BIT);
    push_exp(10'b11001_00111);
    ser_csn = 1'b1;
    wait_cyc(8);
    check("R9 last ten", {22'd0, code_o}, {22'd0, 10'b11001_00111});

    // R11: coincident last clock and select rise
    send_coincident(10'b01110_10001);
    check("R11 word", {22'd0, code_o}, {22'd0, 10'b01110_10001});

    // R7 loopback enable
    lpbk_n = 1'b0;
    wait_cyc(5);
    check("R7 on", {31'd0, lpbk_on}, 32'd1);
    lpbk_n = 1'b1;
    wait_cyc(5);
    check("R7 off", {31'd0, lpbk_on}, 32'd0);

    wait_cyc(10);
    check("R10 all strobes seen", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule